// File: doc/BRIEF.md
# Run-Length Expanding Byte Stream

This block expands run-length encoded receive traffic in hardware. It sits between a parallel-port receive path and a byte FIFO. Each input byte carries a tag that says which channel it arrived on: the command channel carries repeat counts, and the data channel carries payload. The tag alone decides how a byte is treated. The byte value plays no part in that choice.

A count byte arms a pending repeat. The next data byte is then written to the output the count plus one times, so a count of 0 gives one copy and a count of 127 gives 128 copies. A data byte with no pending count passes through once. Both sides use valid/ready handshakes. While copies are still being delivered, the block accepts no input. Compression of outgoing data is not part of this block.

Top module: `rle_expand`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and in_ready is 1.
- R2: A data byte (in_is_cmd=0) with no pending count appears exactly once on out_byte.
- R3: A command byte whose bit 7 is 0 arms a count N from bits 6:0. The next data byte is then output N+1 times, with an unchanged value throughout the run. N=0 yields one copy.
- R4: A count of 127 yields exactly 128 copies, and no run ever exceeds 128 copies.
- R5: Channel is decided by in_is_cmd only. A data-channel byte passes through whatever its value, and a command-channel byte never appears on the output.
- R6: A command byte with bit 7 set is discarded. It produces no output and leaves any pending count as it was.
- R7: A second count byte that arrives before any data byte replaces the pending count.
- R8: While out_valid is 1, in_ready is 0, so no byte is accepted until the last copy has been taken.
- R9: While out_valid is 1 and out_ready is 0, out_valid and out_byte hold steady.
- R10: A count applies only to the data byte right after it. Later data bytes pass once.
- R11: A synchronous reset in the middle of a run, or while a count is pending, cancels the run and the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_is_cmd | input | 1 | 1: byte came on the command channel; 0: data channel |
| in_byte | input | DATA_W | Input byte |
| out_valid | output | 1 | Output copy valid |
| out_ready | input | 1 | Downstream takes the copy |
| out_byte | output | DATA_W | Expanded data byte |

## Verification
The hardest states to reach from the ports are the ones in the middle of a long run. Examples are a reset that lands partway through a repeat, or a stalled consumer while several copies remain. To reach them, the bench stalls out_ready and then grants a few copies one at a time. Between grants it checks in_ready, and only then does it drain or reset. The 128-copy run and the replace and discard cases for a pending count are each built by a dedicated ordering of command and data bytes.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_DATA  = 2'd1,
    K_COUNT = 2'd2,
    K_OTHER = 2'd3
  } kind_e;
endpackage

// File: rtl/rle_classify.sv
module rle_classify
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              fire,
  input  logic              is_cmd,
  input  logic [DATA_W-1:0] byte_in,
  output kind_e             kind,
  output logic [CNT_W-1:0]  cnt
);
  logic upper_set;

  generate
    if (DATA_W > CNT_W) begin : g_upper
      assign upper_set = |byte_in[DATA_W-1:CNT_W];
    end else begin : g_noupper
      assign upper_set = 1'b0;
    end
  endgenerate

  assign cnt = byte_in[CNT_W-1:0];

  always_comb begin
    if (!fire)          kind = K_NONE;
    else if (!is_cmd)   kind = K_DATA;
    else if (upper_set) kind = K_OTHER;
    else                kind = K_COUNT;
  end
endmodule

// File: rtl/rle_run_ctr.sv
module rle_run_ctr
  import rle_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  kind_e            kind,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             take,
  output logic             last
);
  logic             pend_vld;
  logic [CNT_W-1:0] pend_cnt;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
      pend_cnt <= '0;
      remain   <= '0;
    end else begin
      case (kind)
        K_COUNT: begin
          pend_vld <= 1'b1;
          pend_cnt <= cnt_in;
        end
        K_DATA: begin
          remain   <= pend_vld ? pend_cnt : '0;
          pend_vld <= 1'b0;
        end
        default: begin
          if (take && remain != '0) remain <= remain - 1'b1;
        end
      endcase
    end
  end

  assign last = (remain == '0);
endmodule

// File: rtl/rle_out_reg.sv
module rle_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  input  logic              last,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (take && last) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rle_expand.sv
module rle_expand
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_cmd,
  input  logic [DATA_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_byte
);
  kind_e            kind;
  logic [CNT_W-1:0] cnt;
  logic             fire;
  logic             take;
  logic             last;

  assign in_ready = ~out_valid;
  assign fire     = in_valid & in_ready;
  assign take     = out_valid & out_ready;

  rle_classify #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cls (
    .fire(fire), .is_cmd(in_is_cmd), .byte_in(in_byte), .kind(kind), .cnt(cnt)
  );

  rle_run_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .kind(kind), .cnt_in(cnt), .take(take), .last(last)
  );

  rle_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .load(kind == K_DATA), .din(in_byte),
    .take(take), .last(last), .valid(out_valid), .dout(out_byte)
  );
endmodule

// File: rtl/rle_expand_chk.sv
module rle_expand_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_is_cmd,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_byte
);
  localparam int MAXRUN = 2 ** CNT_W;
  logic [CNT_W+1:0] copies;

  always_ff @(posedge clk) begin
    if (rst) copies <= '0;
    else if (in_valid && in_ready && !in_is_cmd) copies <= '0;
    else if (out_valid && out_ready) copies <= copies + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

  // R8
  hold_ready_chk: assert property (@(posedge clk) disable iff (rst) out_valid |-> !in_ready);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  // R3
  run_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> $stable(out_byte));

  // R4
  run_len_chk: assert property (@(posedge clk) disable iff (rst) copies <= MAXRUN);

  // R5
  cmd_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_is_cmd) |=> !out_valid);
endmodule

bind rle_expand rle_expand_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_is_cmd(in_is_cmd), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte)
);

// File: tb/sim_rle_expand.sv
module sim_rle_expand;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_is_cmd = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_byte;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rle_expand u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_cmd(in_is_cmd), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic cmd, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_is_cmd = cmd; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_is_cmd = 1'b0;
  endtask

  task automatic drain(input string req, input logic [7:0] exp_b, output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!out_valid) break;
      if (out_byte != exp_b) chk({req, " byte"}, out_byte, exp_b);
      n++;
      out_ready = 1'b1;
    end
    out_ready = 1'b0;
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst = 1'b1; out_ready = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_pass();
    int n;
    send(1'b0, 8'h05); drain("R2", 8'h05, n); chk("R2/R5 copies", n, 1);
    send(1'b0, 8'hC3); drain("R5", 8'hC3, n); chk("R5 high data copies", n, 1);
  endtask

  task automatic t_counts();
    int n;
    send(1'b1, 8'h00); send(1'b0, 8'hA1); drain("R3", 8'hA1, n); chk("R3 count0", n, 1);
    send(1'b1, 8'h04); send(1'b0, 8'h3C); drain("R3", 8'h3C, n); chk("R3 count4", n, 5);
    send(1'b1, 8'h7F); send(1'b0, 8'hE7); drain("R4", 8'hE7, n); chk("R4 count127", n, 128);
  endtask

  task automatic t_cmd_silent();
    send(1'b1, 8'h90);
    repeat (3) @(negedge clk);
    chk("R5/R6 no output", out_valid, 0);
  endtask

  task automatic t_discard_keep();
    int n;
    send(1'b1, 8'h02); send(1'b1, 8'h85); send(1'b0, 8'h44);
    drain("R6", 8'h44, n); chk("R6 pending kept", n, 3);
  endtask

  task automatic t_replace();
    int n;
    send(1'b1, 8'h09); send(1'b1, 8'h01); send(1'b0, 8'h5A);
    drain("R7", 8'h5A, n); chk("R7 replaced count", n, 2);
  endtask

  task automatic t_once();
    int n;
    send(1'b1, 8'h02); send(1'b0, 8'h11); drain("R10", 8'h11, n); chk("R10 first", n, 3);
    send(1'b0, 8'h22); drain("R10", 8'h22, n); chk("R10 second once", n, 1);
  endtask

  task automatic t_stall();
    int n;
    send(1'b1, 8'h03); send(1'b0, 8'h55);
    repeat (3) @(negedge clk);
    chk("R9 valid held", out_valid, 1);
    chk("R9 byte held", out_byte, 8'h55);
    chk("R8 ready low", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    @(negedge clk);
    chk("R8 ready low mid-run", in_ready, 0);
    chk("R9 valid after one", out_valid, 1);
    drain("R8", 8'h55, n); chk("R8 remaining copies", n, 3);
    chk("R8 ready after run", in_ready, 1);
  endtask

  task automatic t_reset_mid();
    int n;
    send(1'b1, 8'h09); send(1'b0, 8'h77);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    pulse_rst();
    chk("R11 valid cleared", out_valid, 0);
    chk("R11 ready", in_ready, 1);
    send(1'b1, 8'h04);
    pulse_rst();
    send(1'b0, 8'h12); drain("R11", 8'h12, n); chk("R11 pending cleared", n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pass();
    t_counts();
    t_cmd_silent();
    t_discard_keep();
    t_replace();
    t_once();
    t_stall();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule